// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (16 by default) and returns the full product of `2*WIDTH` bits. No product bit is dropped. The product tree has no clock. It is built by recursion. The smallest cell is either a 2x2 cell made of AND gates and half adders, or a 4x4 cell that forms all of its column sums at the same time. Every level above the smallest cell splits each operand into a low half and a high half, forms the four half-width products in parallel, and joins them with three ripple-carry adders. Each adder is a separate module, so another adder circuit can be swapped in without touching the tree.

One register stage wraps the tree, with a valid/ready handshake on each side. An operand pair is taken on a clock edge where `in_valid` and `in_ready` are both high. Its product appears on `product` with `out_valid` high from the next cycle on. While `out_valid` is high and `out_ready` is low, the output is held and `in_ready` is low, so back-pressure reaches the input in the same cycle. When `out_ready` is high, `in_ready` is high, so the block can take one pair every cycle.

Top module: `utm_mul_stream`

## Requirements
- R1: `product` equals the unsigned product `op_a * op_b` of the accepted pair, in all `2*WIDTH` bits.
- R2: With `USE_COLUMN_CELL = 0`, the smallest cell is 2x2. Its bit 0 is x0&y0. Bits 1 and 2 come from a half adder on x1y0 and x0y1, then a half adder on that carry and x1y1. Bit 3 is the last carry. The full product still meets R1.
- R3: With `USE_COLUMN_CELL = 1` (the default), the smallest cell is 4x4. Column k (k = 0..6) adds every xi·yj with i+j = k, plus the carry from column k-1. That carry may be several bits wide. The carry out of column 6 becomes product bit 7, and it is never more than 1.
- R4: Each level above the smallest cell forms four half-width products. Bits [H-1:0] of the low-by-low product go straight to product bits [H-1:0], where H is half the level width. The other bits come from three ripple-carry adders.
- R5: No adder in the tree drops a carry. Both the middle sum and the top sum have a zero carry out, and all-ones times all-ones gives 32'hFFFE0001 at the default width.
- R6: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R7: A pair taken at a clock edge gives `out_valid` = 1 and its product from the next cycle on.
- R8: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0. During that time `product` and `out_valid` hold, and changes on `op_a`, `op_b` and `in_valid` have no effect.
- R9: When `out_ready` = 1, `in_ready` = 1, and a new pair is taken in the same cycle that the held product is consumed. The block can take one pair every cycle.
- R10: After a product is consumed while no new pair is taken, `out_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The block can take a pair in this cycle |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| out_valid | output | 1 | `product` holds a result |
| out_ready | input | 1 | The consumer takes the result |
| product | output | 2*WIDTH | Full unsigned product |

## Verification
A wrong column carry or a lost adder carry inside the tree shows up as a wrong product bit. It appears one cycle after the pair is taken, and only for operands that fill the affected column or half. This is why the bench uses all-ones, single-bit and alternating patterns, plus many random pairs, on both smallest-cell variants. A fault in the handshake state shows up right away at the ports. The symptoms are a product that changes while it is stalled, `in_ready` high during a stall, or `out_valid` that stays high after the result is consumed.

// File: rtl/utm_pkg.sv
package utm_pkg;
  localparam int unsigned UTM_COL_CELL_W = 4;
  localparam int unsigned UTM_LEAF_W     = 2;

  function automatic bit utm_is_pow2(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/utm_half_add.sv
module utm_half_add (
  input  logic a,
  input  logic b,
  output logic s,
  output logic c
);
  assign s = a ^ b;
  assign c = a & b;
endmodule

// File: rtl/utm_full_add.sv
module utm_full_add (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/utm_rca.sv
module utm_rca #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         ci,
  output logic [N-1:0] sum,
  output logic         co
);
  logic [N:0] chain;
  assign chain[0] = ci;

  for (genvar k = 0; k < N; k++) begin : g_bit
    utm_full_add u_fa (
      .a (a[k]),
      .b (b[k]),
      .ci(chain[k]),
      .s (sum[k]),
      .co(chain[k+1])
    );
  end

  assign co = chain[N];
endmodule

// File: rtl/utm_leaf2.sv
module utm_leaf2 (
  input  logic [1:0] x,
  input  logic [1:0] y,
  output logic [3:0] p
);
  logic pp00, pp10, pp01, pp11;
  logic mid_c, top_c;

  // four AND gates
  assign pp00 = x[0] & y[0];
  assign pp10 = x[1] & y[0];
  assign pp01 = x[0] & y[1];
  assign pp11 = x[1] & y[1];

  // crosswise column
  utm_half_add u_ha_mid (.a(pp10), .b(pp01), .s(p[1]), .c(mid_c));
  // vertical upper column plus crosswise carry
  utm_half_add u_ha_top (.a(mid_c), .b(pp11), .s(p[2]), .c(top_c));

  assign p[0] = pp00;
  assign p[3] = top_c;
endmodule

// File: rtl/utm_col4.sv
module utm_col4 #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]   x,
  input  logic [N-1:0]   y,
  output logic [2*N-1:0] p
);
  localparam int unsigned NCOL = 2 * N - 1;
  localparam int unsigned AW   = $clog2(2 * N);
  localparam int unsigned CW   = AW - 1;

  logic [AW-1:0] acc;
  logic [CW-1:0] carry;

  // every column sum formed in the same combinational pass
  always_comb begin
    carry = '0;
    acc   = '0;
    p     = '0;
    for (int k = 0; k < NCOL; k++) begin
      acc = {1'b0, carry};
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (i + j == k) acc = acc + AW'(x[i] & y[j]);
        end
      end
      p[k]  = acc[0];
      carry = acc[AW-1:1];
    end
    p[2*N-1] = carry[0];
  end

  // R3: the carry leaving the last column fits in the single MSB
  always_comb begin
    assert_col_msb_fits_R3: assert (carry[CW-1:1] == '0)
      else $error("column cell final carry wider than one bit");
  end
endmodule

// File: rtl/utm_node.sv
module utm_node #(
  parameter int unsigned W       = 16,
  parameter bit          USE_COL = 1'b1
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  import utm_pkg::*;
  localparam int unsigned H = W / 2;

  if (W == UTM_LEAF_W) begin : g_leaf
    utm_leaf2 u_leaf (.x(x), .y(y), .p(p));
  end else if (W == UTM_COL_CELL_W && USE_COL) begin : g_col
    utm_col4 #(.N(W)) u_col (.x(x), .y(y), .p(p));
  end else begin : g_split
    logic [W-1:0] ll, lh, hl, hh;
    logic [W-1:0] cross_sum;
    logic         cross_c;
    logic [W:0]   mid_sum;
    logic         mid_c;
    logic [W-1:0] top_sum;
    logic         top_c;

    utm_node #(.W(H), .USE_COL(USE_COL)) u_ll (.x(x[H-1:0]), .y(y[H-1:0]), .p(ll));
    utm_node #(.W(H), .USE_COL(USE_COL)) u_lh (.x(x[H-1:0]), .y(y[W-1:H]), .p(lh));
    utm_node #(.W(H), .USE_COL(USE_COL)) u_hl (.x(x[W-1:H]), .y(y[H-1:0]), .p(hl));
    utm_node #(.W(H), .USE_COL(USE_COL)) u_hh (.x(x[W-1:H]), .y(y[W-1:H]), .p(hh));

    // adder 1: the two crosswise products
    utm_rca #(.N(W)) u_add_cross (
      .a(lh), .b(hl), .ci(1'b0), .sum(cross_sum), .co(cross_c)
    );
    // adder 2: crosswise sum plus upper half of low-by-low
    utm_rca #(.N(W+1)) u_add_mid (
      .a({cross_c, cross_sum}),
      .b({{(H+1){1'b0}}, ll[W-1:H]}),
      .ci(1'b0), .sum(mid_sum), .co(mid_c)
    );
    // adder 3: high-by-high plus upper part of the middle sum
    utm_rca #(.N(W)) u_add_top (
      .a(hh),
      .b({{(H-1){1'b0}}, mid_sum[W:H]}),
      .ci(1'b0), .sum(top_sum), .co(top_c)
    );

    assign p = {top_sum, mid_sum[H-1:0], ll[H-1:0]};

    // R5: neither wide adder may overflow, otherwise a product bit is lost
    always_comb begin
      assert_mid_no_carry_R5: assert (mid_c == 1'b0)
        else $error("middle adder carried out");
      assert_top_no_carry_R5: assert (top_c == 1'b0)
        else $error("top adder carried out");
    end
  end
endmodule

// File: rtl/utm_mul_stream.sv
module utm_mul_stream #(
  parameter int unsigned WIDTH           = 16,
  parameter bit          USE_COLUMN_CELL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2*WIDTH-1:0] product
);
  import utm_pkg::*;
  localparam int unsigned PW = 2 * WIDTH;

  if (!utm_is_pow2(WIDTH)) begin : g_bad_width
    $error("WIDTH must be a power of two");
  end

  logic [PW-1:0] tree_p;
  logic          take;

  utm_node #(.W(WIDTH), .USE_COL(USE_COLUMN_CELL)) u_tree (
    .x(op_a), .y(op_b), .p(tree_p)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      product   <= tree_p;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  logic [PW-1:0] a_wide, b_wide;
  assign a_wide = {{WIDTH{1'b0}}, op_a};
  assign b_wide = {{WIDTH{1'b0}}, op_b};

  assert_reset_idle_R6: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));

  assert_product_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && product == $past(a_wide) * $past(b_wide)));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(product)));

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: tb/test_utm_mul_stream.sv
module test_utm_mul_stream;
  localparam int unsigned W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;

  logic in_ready_c, out_valid_c, in_ready_l, out_valid_l;
  logic [2*W-1:0] product_c, product_l;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  utm_mul_stream #(.WIDTH(W), .USE_COLUMN_CELL(1'b1)) i_utm_mul_stream (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_c),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid_c), .out_ready(out_ready),
    .product(product_c)
  );

  utm_mul_stream #(.WIDTH(W), .USE_COLUMN_CELL(1'b0)) i_utm_mul_stream_leaf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_l),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid_l), .out_ready(out_ready),
    .product(product_l)
  );

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  bit             pend = 1'b0;
  logic [2*W-1:0] pend_exp;
  string          pend_tag;

  // called at a falling edge: check the pair taken at the last rising edge, offer a new one
  task automatic stream_pair(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    if (pend) begin
      chk(out_valid_c && product_c == pend_exp, {pend_tag, " R3 column-cell product"},
          64'(product_c), 64'(pend_exp));
      chk(out_valid_l && product_l == pend_exp, {pend_tag, " R2 leaf-cell product"},
          64'(product_l), 64'(pend_exp));
    end
    op_a = a; op_b = b; in_valid = 1'b1; out_ready = 1'b1;
    pend = 1'b1; pend_exp = ref_mul(a, b); pend_tag = tag;
  endtask

  logic [W-1:0] corners [22];

  initial begin
    void'($urandom(32'd20240517));
    corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h0F0F;
    corners[3] = 16'hAAAA; corners[4] = 16'h5555; corners[5] = 16'hF0F0;
    for (int k = 0; k < 16; k++) corners[6+k] = 16'(1) << k;

    // R6: reset state
    repeat (3) @(negedge clk);
    chk(!out_valid_c && in_ready_c, "R6 reset out_valid/in_ready",
        64'({out_valid_c, in_ready_c}), 64'(2'b01));
    chk(!out_valid_l && in_ready_l, "R6 reset leaf out_valid/in_ready",
        64'({out_valid_l, in_ready_l}), 64'(2'b01));
    rst_n = 1'b1;

    // R7/R8: single pair under back-pressure
    @(negedge clk);
    op_a = 16'h1234; op_b = 16'h5678; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid_c && product_c == ref_mul(16'h1234, 16'h5678), "R7 product one cycle after take",
        64'(product_c), 64'(ref_mul(16'h1234, 16'h5678)));
    chk(!in_ready_c, "R8 in_ready low while stalled", 64'(in_ready_c), 64'(0));
    op_a = 16'hFFFF; op_b = 16'hFFFF;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk(out_valid_c && product_c == 32'h06260060, "R8 held product ignores new inputs",
          64'(product_c), 64'(32'h06260060));
      chk(!in_ready_c, "R8 in_ready stays low", 64'(in_ready_c), 64'(0));
      op_a = op_a ^ 16'h00FF;
    end
    out_ready = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid_c && in_ready_c, "R10 out_valid drops after consume",
        64'({out_valid_c, in_ready_c}), 64'(2'b01));

    // directed level-structure and carry cases
    stream_pair(16'h00FF, 16'h00FF, "R4 low-by-low only");
    stream_pair(16'h0100, 16'h0100, "R4 high-by-high only");
    stream_pair(16'h0003, 16'hFF00, "R4 crosswise only");
    stream_pair(16'hFFFF, 16'hFFFF, "R5 all ones");
    stream_pair(16'h000F, 16'h000F, "R3 full low nibble columns");
    @(negedge clk);
    chk(out_valid_c && product_c == 32'h000000E1, "R3 nibble product literal",
        64'(product_c), 64'(32'h000000E1));
    op_a = 16'hFFFF; op_b = 16'hFFFF; pend_exp = ref_mul(16'hFFFF, 16'hFFFF);
    pend_tag = "R5 all-ones literal";
    @(negedge clk);
    chk(product_c == 32'hFFFE0001 && product_l == 32'hFFFE0001, "R5 all-ones literal",
        64'(product_c), 64'(32'hFFFE0001));
    pend = 1'b0;

    // corner operand matrix, streamed back to back (R9)
    for (int i = 0; i < 22; i++)
      for (int j = 0; j < 22; j++)
        stream_pair(corners[i], corners[j], "R1 R9 corner pair");

    // random pairs, streamed back to back
    for (int n = 0; n < 10000; n++)
      stream_pair(16'($urandom), 16'($urandom), "R1 R9 random pair");

    @(negedge clk);
    chk(out_valid_c && product_c == pend_exp, "R1 last column-cell product",
        64'(product_c), 64'(pend_exp));
    chk(out_valid_l && product_l == pend_exp, "R2 last leaf-cell product",
        64'(product_l), 64'(pend_exp));
    in_valid = 1'b0; pend = 1'b0;
    @(negedge clk);
    chk(!out_valid_c && !out_valid_l, "R10 idle after stream drains",
        64'({out_valid_c, out_valid_l}), 64'(0));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule